// File: doc/BRIEF.md
# ROM Cartridge Read Sequencer

This block reads bytes from a 16 KB EPROM behind a cartridge-style ROM port. A single read takes a 14-bit offset into the cartridge window. A dump command reads the whole cartridge in order, one byte at a time. For each byte the block does four things in a fixed order:

- it turns the chip off and places the new address on the 16-bit bus;
- it turns the chip on and raises the port enable;
- it holds for a wait long enough to cover the EPROM access time;
- it captures the data bus and reports the byte with a one-cycle strobe.

The block rebuilds the cartridge decode itself. The EPROM output enable goes low only when both top address bits and the port enable are high. The programming pin is held inactive at all times. The wait length comes from two parameters, the clock period in nanoseconds and the access time of the speed grade in use.

Top module: `rom_cart_reader`

## Requirements
- R1: Every address driven while the chip is enabled has bits 15 and 14 set, and equals 0xC000 plus the requested offset.
- R2: `rom_oe_n` is 0 exactly when `rom_addr[15]`, `rom_addr[14]` and `port_en` are all 1, and 1 otherwise.
- R3: For each byte, the new address is first driven for one cycle with `rom_ce_n`=1 and `port_en`=0. Then `rom_ce_n` goes to 0 and `port_en` to 1. The address never changes while `rom_ce_n` is 0.
- R4: The chip stays enabled for W = ceil(ACCESS_NS/CLK_NS)+1 cycles. The byte is sampled at the end of that window, and `rd_valid` is high in the cycle after the last enabled cycle. For a single read accepted at clock edge 0, `rd_valid` is seen after edge W+1.
- R5: ACCESS_NS selects the speed grade: 200, 250 (default) or 300 ns. With CLK_NS=50 and ACCESS_NS=300, `rd_valid` appears after edge 8.
- R6: `rom_pgm_n` is 1 at all times.
- R7: `rd_data` changes only together with a `rd_valid` pulse. Data on the bus while the chip is disabled, or before the wait has run out, is never captured.
- R8: `dump_req` reads offsets 0 through 16383 in ascending order, one `rd_valid` pulse per byte, at a spacing of W+1 cycles. `done` pulses together with the last byte. `dump_req` wins over `rd_req` when both are high.
- R9: `busy` is high from the cycle after a request is accepted until the `rd_valid` pulse of the last byte, and low in that cycle. Requests that arrive while `busy` is high are ignored.
- R10: When idle, `port_en` is 0, `rom_ce_n` is 1, and `rom_addr` holds the last value driven.
- R11: After reset the block is idle with `rom_addr`=0xC000, `rd_data`=0, `rd_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Single-byte read request, accepted when idle |
| rd_off | input | 14 | Byte offset for a single read |
| dump_req | input | 1 | Read the whole cartridge, accepted when idle |
| rom_addr | output | 16 | Address bus to the cartridge |
| rom_data | input | 8 | Data bus from the cartridge |
| port_en | output | 1 | Active-high port enable |
| rom_oe_n | output | 1 | Decoded output enable, active low |
| rom_ce_n | output | 1 | Chip enable, active low |
| rom_pgm_n | output | 1 | Program control, held inactive high |
| busy | output | 1 | Read or dump in progress |
| rd_valid | output | 1 | One-cycle strobe marking a captured byte |
| rd_data | output | 8 | Captured byte |
| done | output | 1 | One-cycle pulse at the end of a dump |

## Verification
The assertions assume that request inputs are driven synchronously and that reset is released between clock edges. They also assume the data bus may carry anything at all while the chip is off. The bench drives every request from the falling edge. It pairs the block with an EPROM model that returns a garbage byte until the enable has been held for the full access time, so a wait that is too short shows up as wrong data. Requests are deliberately raised while a read is in flight, and both requests are raised together. The bench compares the block against its model on every cycle.

// File: rtl/rom_cart_reader.sv
module rom_cart_reader #(
  parameter int CLK_NS    = 4,
  parameter int ACCESS_NS = 250,
  parameter int OFF_W     = 14,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              dump_req,
  output logic [OFF_W+1:0]  rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              port_en,
  output logic              rom_oe_n,
  output logic              rom_ce_n,
  output logic              rom_pgm_n,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam int WAIT  = (ACCESS_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int CNT_W = $clog2(WAIT);
  localparam logic [OFF_W-1:0]  LAST_OFF = '1;
  localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(WAIT - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACCESS} st_t;
  st_t st;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt;
  logic             dumping;

  assign rom_addr  = {2'b11, off_q};
  assign port_en   = (st == S_ACCESS);
  assign rom_ce_n  = ~port_en;
  assign rom_oe_n  = ~(rom_addr[OFF_W+1] & rom_addr[OFF_W] & port_en);
  assign rom_pgm_n = 1'b1;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      off_q    <= '0;
      cnt      <= '0;
      dumping  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      unique case (st)
        S_IDLE: if (dump_req || rd_req) begin
          off_q   <= dump_req ? '0 : rd_off;
          dumping <= dump_req;
          st      <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_ACCESS;
        end
        S_ACCESS: if (cnt == CNT_END) begin
          rd_data  <= rom_data;
          rd_valid <= 1'b1;
          if (dumping && off_q != LAST_OFF) begin
            off_q <= off_q + 1'b1;
            st    <= S_SETUP;
          end else begin
            done    <= dumping;
            dumping <= 1'b0;
            st      <= S_IDLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module rom_cart_reader_chk #(
  parameter int OFF_W  = 14,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OFF_W+1:0]  rom_addr,
  input logic              port_en,
  input logic              rom_oe_n,
  input logic              rom_ce_n,
  input logic              busy,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              done
);
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> rom_addr[OFF_W+1:OFF_W] == 2'b11); // R1
  AST_OE_NEEDS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> port_en); // R2
  AST_ADDR_MOVES_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_addr) |-> rom_ce_n); // R3
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data)); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R8
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rd_valid); // R8
  AST_BUSY_ENDS_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rd_valid); // R9
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rom_ce_n && !port_en)); // R10
endmodule

bind rom_cart_reader rom_cart_reader_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .port_en(port_en),
  .rom_oe_n(rom_oe_n), .rom_ce_n(rom_ce_n), .busy(busy),
  .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
);

// File: tb/rom_cart_reader_bench.sv
module rom_cart_reader_bench;
  localparam int CLK_NS = 50;
  localparam int ACC_NS = 250;
  localparam int W      = (ACC_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int ACC_CY = (ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int P      = W + 1;

  logic clk = 0, rst_n = 0;
  logic rd_req = 0, dump_req = 0, slow_req = 0;
  logic [13:0] rd_off = '0;
  logic [15:0] rom_addr, s_addr;
  logic [7:0]  rom_data, rd_data, s_data;
  logic port_en, rom_oe_n, rom_ce_n, rom_pgm_n, busy, rd_valid, done;
  logic s_pe, s_oe, s_ce, s_pg, s_busy, s_valid, s_done;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rom_cart_reader #(.CLK_NS(CLK_NS), .ACCESS_NS(ACC_NS)) u_rom_cart_reader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_off(rd_off), .dump_req(dump_req),
    .rom_addr(rom_addr), .rom_data(rom_data), .port_en(port_en), .rom_oe_n(rom_oe_n),
    .rom_ce_n(rom_ce_n), .rom_pgm_n(rom_pgm_n), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done));

  rom_cart_reader #(.CLK_NS(CLK_NS), .ACCESS_NS(300)) u_slow (
    .clk(clk), .rst_n(rst_n), .rd_req(slow_req), .rd_off(14'h0), .dump_req(1'b0),
    .rom_addr(s_addr), .rom_data(8'h5A), .port_en(s_pe), .rom_oe_n(s_oe),
    .rom_ce_n(s_ce), .rom_pgm_n(s_pg), .busy(s_busy), .rd_valid(s_valid),
    .rd_data(s_data), .done(s_done));

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[13:8], 2'b10} ^ 8'h3C;
  endfunction

  // EPROM model: real data only after the enable has been held long enough
  int en_cy = 0;
  always @(posedge clk) begin
    if (rom_ce_n || rom_oe_n) en_cy <= 0;
    else en_cy <= en_cy + 1;
  end
  assign rom_data = (en_cy >= ACC_CY) ? pat(rom_addr) : 8'hEE;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // requests as seen by the block at the rising edge
  logic seen_rd = 0, seen_dump = 0;
  logic [13:0] seen_off = '0;
  always @(posedge clk) begin
    seen_rd   <= rd_req && rst_n;
    seen_dump <= dump_req && rst_n;
    seen_off  <= rd_off;
  end

  bit m_act = 0, m_dump = 0, run = 0;
  int s = 0, m_n = 0, m_off = 0;
  int last_addr = 'hC000, last_data = 0;

  always @(negedge clk) if (run) begin
    int e_addr, idx;
    bit e_busy, e_valid, e_en, e_done;
    if (m_act) s++;
    else if (seen_rd || seen_dump) begin
      m_act = 1; s = 0; m_dump = seen_dump;
      m_off = seen_dump ? 0 : int'(seen_off);
      m_n   = seen_dump ? 16384 : 1;
    end
    if (m_act) begin
      e_busy  = s < m_n * P;
      e_valid = (s > 0) && (s % P == 0);
      e_en    = e_busy && (s % P != 0);
      e_done  = m_dump && (s == m_n * P);
      idx     = (s / P < m_n) ? s / P : m_n - 1;
      e_addr  = 'hC000 | (m_off + idx);
    end else begin
      e_busy = 0; e_valid = 0; e_en = 0; e_done = 0; e_addr = last_addr;
    end
    chk(busy == e_busy, "R9 busy", busy, e_busy);
    chk(rd_valid == e_valid, "R4/R8 rd_valid", rd_valid, e_valid);
    chk(rom_ce_n == !e_en, "R3/R10 rom_ce_n", rom_ce_n, !e_en);
    chk(port_en == e_en, "R3/R10 port_en", port_en, e_en);
    chk(int'(rom_addr) == e_addr, "R1/R10 rom_addr", rom_addr, e_addr);
    chk(rom_oe_n == !(rom_addr[15] && rom_addr[14] && port_en), "R2 rom_oe_n", rom_oe_n,
        !(rom_addr[15] && rom_addr[14] && port_en));
    chk(rom_pgm_n == 1'b1, "R6 rom_pgm_n", rom_pgm_n, 1);
    chk(done == e_done, "R8 done", done, e_done);
    if (e_valid) last_data = pat(16'('hC000 | (m_off + s / P - 1)));
    chk(int'(rd_data) == last_data, "R7 rd_data", rd_data, last_data);
    if (m_act && s == m_n * P) begin m_act = 0; last_addr = e_addr; end
  end

  task automatic one_read(input logic [13:0] off);
    @(negedge clk); rd_req = 1; rd_off = off;
    @(negedge clk); rd_req = 0;
    repeat (P + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && rd_valid == 0 && done == 0, "R11 flags", {busy, rd_valid, done}, 0);
    chk(rom_addr == 16'hC000, "R11 rom_addr", rom_addr, 'hC000);
    chk(rd_data == 8'h00, "R11 rd_data", rd_data, 0);
    chk(rom_ce_n && !port_en, "R11 enables", {rom_ce_n, port_en}, 2);
    rst_n = 1;
    @(negedge clk); run = 1;
    repeat (2) @(negedge clk);
    // single reads across the window
    one_read(14'h0000);
    one_read(14'h1234);
    one_read(14'h3FFF);
    one_read(14'h2AAA);
    // R9: requests while busy are ignored
    @(negedge clk); rd_req = 1; rd_off = 14'h0155;
    @(negedge clk); rd_req = 0;
    repeat (2) @(negedge clk);
    rd_req = 1; rd_off = 14'h3001;
    @(negedge clk); rd_req = 0; dump_req = 1;
    @(negedge clk); dump_req = 0;
    repeat (P + 3) @(negedge clk);
    // R10: idle gap, address must hold
    repeat (5) @(negedge clk);
    // R5: 300 ns grade gives valid after edge 8
    begin
      int n = 0;
      @(negedge clk); slow_req = 1;
      @(negedge clk); slow_req = 0;
      while (!s_valid && n < 20) begin @(negedge clk); n++; end
      chk(n == 8, "R5 slow grade latency", n, 8);
      chk(s_data == 8'h5A, "R5 slow grade data", s_data, 'h5A);
    end
    // R8: full dump, dump wins over a simultaneous read
    @(negedge clk); dump_req = 1; rd_req = 1; rd_off = 14'h0777;
    @(negedge clk); dump_req = 0; rd_req = 0;
    repeat (16384 * P + 4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule